// File: doc/BRIEF.md
# Multichannel Chaotic Stream Encryptor

This block is the sending side of a chaos-based link that protects three parallel byte streams with one shared state machine. It holds a seven-variable discrete-time map in signed Q16.16 fixed point. The last three state variables serve as 32-bit keystream words, one for each channel. When the block accepts a set of three plaintext bytes, each byte is XORed into the low byte of its keystream word. The resulting ciphertext words are then written back into the map, and the map advances one step. A receiver that runs the same map, driven by the ciphertext it receives, falls into step with the sender.

Each map step is a linear matrix product plus a bounded control term. The control term is added only to the equations of the three keystream variables. The block computes one matrix row per clock cycle. While those rows are being computed, it sends the three ciphertext bytes in fixed channel order on one byte lane, each tagged with its channel number. Coefficients, gains, the control bound and the initial state are all parameters.

Top module: `chaos_tdm_encryptor`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0, and the state vector equals the INIT_X parameter. This is visible because the first ciphertexts equal the plaintext XOR the low bytes of INIT_X variables 4, 5 and 6.
- R2: A pixel set is accepted on a clock edge where in_valid_i and in_ready_o are both 1. A set offered while in_ready_o is 0 has no effect on any later output.
- R3: Channel c (0..2) takes its plaintext from in_pix_i[8c+7:8c]. Its keystream word is state variable 4+c. Its ciphertext byte is the plaintext XOR bits 7:0 of that word.
- R4: In the three cycles right after acceptance, out_valid_o is 1 and out_chan_o is 0, then 1, then 2. out_data_o carries that channel's ciphertext byte. out_valid_o is 0 at all other times.
- R5: The feedback word of channel c is its keystream word with bits 7:0 replaced by the ciphertext byte. In the next step, that word takes the place of variable 4+c in every row equation except row 4+c.
- R6: New variable r = sum over j of the wrapped 32-bit value (A[r][j]*y[j]) >>> 16, where y is the fed-back vector of R5 and A[r][j] is A_MAT bits [(7r+j)*32 +: 32].
- R7: Row 4+c also adds a control term: (G[c]*x[4+c]) >>> 16, with x the state before feedback, kept to its low CTRL_W bits and sign-extended. G[c] is G_VEC bits [32c +: 32].
- R8: After acceptance, in_ready_o is 0 for exactly N=7 cycles and then returns to 1.
- R9: Asserting rst_ni in the middle of a step drops out_valid_o, raises in_ready_o and restores INIT_X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A plaintext set is offered |
| in_ready_o | output | 1 | Block can accept a set |
| in_pix_i | input | 24 | Three plaintext bytes, channel c in bits 8c+7:8c |
| out_valid_o | output | 1 | Ciphertext byte present |
| out_chan_o | output | 2 | Channel tag of out_data_o |
| out_data_o | output | 8 | Ciphertext byte |

## Verification
Sending the ciphertext bytes overlaps the first three row computations of the map, and these two activities read the same held ciphertext words in the same cycles. The bench checks every byte in its exact cycle. Across a long chain of steps, the bytes must keep matching a bit-exact model. A single wrong feedback value or row would make every later byte differ. The bench also offers junk input in the same cycles as these computations, and checks that it leaves no trace in any later output.

// File: rtl/chaos_pkg.sv
package chaos_pkg;
  localparam int DW    = 32;
  localparam int FRAC  = 16;
  localparam int DEF_N = 7;
  localparam int DEF_M = 3;

  // 0.5 on the diagonal, 0.25 on the cyclic superdiagonal
  function automatic logic [DEF_N*DEF_N*DW-1:0] default_amat();
    logic [DEF_N*DEF_N*DW-1:0] v;
    v = '0;
    for (int r = 0; r < DEF_N; r++) begin
      v[(r*DEF_N+r)*DW +: DW] = 32'h0000_8000;
      v[(r*DEF_N+((r+1)%DEF_N))*DW +: DW] = 32'h0000_4000;
    end
    return v;
  endfunction

  function automatic logic [DEF_M*DW-1:0] default_gain();
    logic [DEF_M*DW-1:0] v;
    for (int c = 0; c < DEF_M; c++) v[c*DW +: DW] = 32'h000C_0000 + 32'(c) * 32'h0001_0000;
    return v;
  endfunction

  function automatic logic [DEF_N*DW-1:0] default_init();
    logic [DEF_N*DW-1:0] v;
    for (int i = 0; i < DEF_N; i++) v[i*DW +: DW] = 32'h0000_1357 + 32'(i) * 32'h0000_2A4D;
    return v;
  endfunction
endpackage

// File: rtl/chaos_cipher_unit.sv
module chaos_cipher_unit #(
  parameter int N  = 7,
  parameter int M  = 3,
  parameter int W  = 32
) (
  input  logic [N*W-1:0] x_i,
  input  logic [M*8-1:0] pix_i,
  output logic [M*W-1:0] fb_o
);
  localparam int FB_BASE = N - M;

  for (genvar c = 0; c < M; c++) begin : g_ch
    assign fb_o[c*W +: W] = x_i[(FB_BASE+c)*W +: W] ^ {{(W-8){1'b0}}, pix_i[c*8 +: 8]};
  end
endmodule

// File: rtl/chaos_map_row.sv
module chaos_map_row #(
  parameter int N      = 7,
  parameter int M      = 3,
  parameter int W      = 32,
  parameter int FRAC   = 16,
  parameter int CTRL_W = 18,
  parameter int RW     = 3,
  parameter logic [N*N*W-1:0] A_MAT = '0,
  parameter logic [M*W-1:0]   G_VEC = '0
) (
  input  logic [RW-1:0]  row_i,
  input  logic [N*W-1:0] x_i,
  input  logic [M*W-1:0] fb_i,
  output logic [W-1:0]   sum_o
);
  localparam int FB_BASE = N - M;

  function automatic logic [W-1:0] fx_mul(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = a * b;
    return p[FRAC +: W];
  endfunction

  logic signed [W-1:0]      a, y, acc, g, xs;
  logic signed [2*W-1:0]    pc;
  logic signed [CTRL_W-1:0] cv;
  int                       r, k;

  always_comb begin
    r   = int'(row_i);
    k   = (r >= FB_BASE) ? r - FB_BASE : 0;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      a = A_MAT[(r*N+j)*W +: W];
      y = x_i[j*W +: W];
      if (j >= FB_BASE && j != r) y = fb_i[(j-FB_BASE)*W +: W];
      acc = acc + fx_mul(a, y);
    end
    g  = G_VEC[k*W +: W];
    xs = x_i[r*W +: W];
    pc = g * xs;
    cv = pc[FRAC +: CTRL_W];
    if (r >= FB_BASE) acc = acc + {{(W-CTRL_W){cv[CTRL_W-1]}}, cv};
    sum_o = acc;
  end
endmodule

// File: rtl/chaos_tdm_encryptor.sv
module chaos_tdm_encryptor #(
  parameter int N      = chaos_pkg::DEF_N,
  parameter int M      = chaos_pkg::DEF_M,
  parameter int W      = chaos_pkg::DW,
  parameter int FRAC   = chaos_pkg::FRAC,
  parameter int CTRL_W = 18,
  parameter logic [N*N*W-1:0] A_MAT  = chaos_pkg::default_amat(),
  parameter logic [M*W-1:0]   G_VEC  = chaos_pkg::default_gain(),
  parameter logic [N*W-1:0]   INIT_X = chaos_pkg::default_init()
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [M*8-1:0]       in_pix_i,
  output logic                 out_valid_o,
  output logic [$clog2(M)-1:0] out_chan_o,
  output logic [7:0]           out_data_o
);
  localparam int RW = $clog2(N);
  localparam int CW = $clog2(M);

  logic          busy_q;
  logic [RW-1:0] row_q;
  logic [N*W-1:0] x_q, nx_q;
  logic [M*W-1:0] fb_q, fb_d;
  logic [W-1:0]   row_sum;
  logic           accept;

  assign accept = in_valid_i & ~busy_q;

  chaos_cipher_unit #(.N(N), .M(M), .W(W)) u_cipher (
    .x_i  (x_q),
    .pix_i(in_pix_i),
    .fb_o (fb_d)
  );

  chaos_map_row #(
    .N(N), .M(M), .W(W), .FRAC(FRAC), .CTRL_W(CTRL_W), .RW(RW),
    .A_MAT(A_MAT), .G_VEC(G_VEC)
  ) u_row (
    .row_i(row_q),
    .x_i  (x_q),
    .fb_i (fb_q),
    .sum_o(row_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      x_q    <= INIT_X;
      nx_q   <= '0;
      fb_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      row_q  <= '0;
      fb_q   <= fb_d;
    end else if (busy_q) begin
      nx_q[int'(row_q)*W +: W] <= row_sum;
      row_q <= row_q + 1'b1;
      if (row_q == RW'(N-1)) begin
        busy_q <= 1'b0;
        for (int i = 0; i < N; i++)
          x_q[i*W +: W] <= (i == N-1) ? row_sum : nx_q[i*W +: W];
      end
    end
  end

  // byte emission overlaps the first M row computations
  assign in_ready_o  = ~busy_q;
  assign out_valid_o = busy_q && (row_q < RW'(M));
  assign out_chan_o  = CW'(row_q);
  assign out_data_o  = fb_q[int'(out_chan_o)*W +: 8];
endmodule

// File: rtl/chaos_tdm_chk.sv
module chaos_tdm_chk #(
  parameter int M = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 in_ready_o,
  input logic                 out_valid_o,
  input logic [$clog2(M)-1:0] out_chan_o
);
  a_r4_first_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && out_chan_o == '0));

  a_r4_chan_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_chan_o != ($clog2(M))'(M-1)) |=>
      (out_valid_o && out_chan_o == $past(out_chan_o) + 1'b1));

  a_r4_last_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_chan_o == ($clog2(M))'(M-1)) |=> !out_valid_o);

  a_r8_busy_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r2_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
endmodule

bind chaos_tdm_encryptor chaos_tdm_chk #(.M(M)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_chan_o (out_chan_o)
);

// File: tb/sim_chaos_tdm_encryptor.sv
`timescale 1ns/1ps
module sim_chaos_tdm_encryptor;
  localparam int N = 7;
  localparam int M = 3;
  localparam logic [N*N*32-1:0] A_D = chaos_pkg::default_amat();
  localparam logic [M*32-1:0]   G_D = chaos_pkg::default_gain();
  localparam logic [N*32-1:0]   X_D = chaos_pkg::default_init();

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [23:0] in_pix_i = '0;
  logic       out_valid_o;
  logic [1:0] out_chan_o;
  logic [7:0] out_data_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  chaos_tdm_encryptor u0 (.*);

  logic signed [31:0] xm [N];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) xm[i] = X_D[i*32 +: 32];
  endtask

  function automatic logic [31:0] mulq(input logic signed [31:0] a, input logic signed [31:0] b);
    logic signed [63:0] p;
    p = a * b;
    return p[47:16];
  endfunction

  task automatic model_step(input logic [23:0] p);
    logic signed [31:0] ct [M];
    logic signed [31:0] nx [N];
    logic signed [31:0] y, acc;
    logic signed [63:0] pr;
    logic signed [17:0] cv;
    for (int c = 0; c < M; c++) ct[c] = xm[4+c] ^ {24'd0, p[c*8 +: 8]};
    for (int r = 0; r < N; r++) begin
      acc = 0;
      for (int j = 0; j < N; j++) begin
        y = (j >= 4 && j != r) ? ct[j-4] : xm[j];
        acc = acc + mulq(A_D[(r*N+j)*32 +: 32], y);
      end
      if (r >= 4) begin
        pr = $signed(G_D[(r-4)*32 +: 32]) * xm[r];
        cv = pr[33:16];
        acc = acc + {{14{cv[17]}}, cv};
      end
      nx[r] = acc;
    end
    for (int i = 0; i < N; i++) xm[i] = nx[i];
  endtask

  // called at a negedge with ready high
  task automatic step(input logic [23:0] p, input bit junk);
    logic [7:0] e [M];
    for (int c = 0; c < M; c++) e[c] = xm[4+c][7:0] ^ p[c*8 +: 8];
    chk("R2 ready before accept", 32'(in_ready_o), 1);
    in_valid_i = 1'b1;
    in_pix_i   = p;
    @(negedge clk_i);
    in_valid_i = junk;
    if (junk) in_pix_i = 24'(~p);
    for (int c = 0; c < M; c++) begin
      chk("R4 valid", 32'(out_valid_o), 1);
      chk("R4 chan", 32'(out_chan_o), 32'(c));
      chk("R3 R5 R6 R7 data", 32'(out_data_o), 32'(e[c]));
      chk("R8 ready low", 32'(in_ready_o), 0);
      @(negedge clk_i);
    end
    for (int k = M; k < N; k++) begin
      chk("R4 idle", 32'(out_valid_o), 0);
      chk("R8 ready low", 32'(in_ready_o), 0);
      @(negedge clk_i);
    end
    chk("R8 ready back", 32'(in_ready_o), 1);
    in_valid_i = 1'b0;
    model_step(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", 32'(in_ready_o), 1);
    chk("R1 valid", 32'(out_valid_o), 0);
    step(24'h000000, 0);   // R1 R3: bytes equal init keystream
    step(24'hFFFFFF, 0);
    step(24'h00FF00, 1);   // R2: junk offered while busy
    for (int i = 0; i < 40; i++) step(24'($urandom), (i % 5) == 0);
    // R9: reset mid-step
    in_valid_i = 1'b1; in_pix_i = 24'h5A5A5A;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 valid", 32'(out_valid_o), 0);
    chk("R9 ready", 32'(in_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk_i);
    step(24'h123456, 0);
    for (int i = 0; i < 20; i++) step(24'($urandom), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule